// File: doc/BRIEF.md
# Cascadable Serial LED Sink Controller

This block is the digital core of a sixteen-channel LED current-sink driver. A host shifts a channel word in one bit at a time over a serial data line and a shift clock. A strobe then copies the shift contents into an output latch, and an active-low output enable gates the latched word onto the channel-on outputs. The most significant shift bit appears on a serial output, so several drivers can be chained into one long shift path.

All external controls are slow, asynchronous pins. They are brought into a fast system clock domain through two-flop synchronizers, and edge detectors turn each rising shift-clock edge into a single-cycle shift event. Switching every channel at once would draw a large step of supply current. Odd-numbered channels therefore follow the even-numbered ones a fixed number of system clocks later, both when they turn on and when they turn off.

Top module: `ledSinkCore`

## Requirements
- R1: `chanOn` has one bit per channel, and bit n high means channel n sinks current. After 16 shifts, the first bit shifted in drives channel 15 and the last bit shifted in drives channel 0.
- R2: Each rising edge of `shiftClk` shifts the word exactly once, taking the level of `serIn`. A high or low level held on `shiftClk` causes no further shift.
- R3: `serOut` shows the most significant shift bit. This is the bit taken 15 shift events before the latest one, and it changes only after a shift event.
- R4: While `strobe` is high, the latch follows the shift register. While `strobe` is low, the latch holds, and later shifts leave `chanOn` unchanged.
- R5: With `outEnN` high, every channel is off whatever the latch holds. With `outEnN` low, the channels show the latch.
- R6: An odd channel changes exactly STAGGER_CYCLES system clocks after the even channels, for turn-on and for turn-off alike (default 2).
- R7: Synchronous active-high `rst` clears the shift register and the latch. It drives `chanOn` to all zero and `serOut` to 0.
- R8: When a shift event lands while `strobe` is high, the latch ends up with the post-shift word, so that word reaches the channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial channel data |
| shiftClk | input | 1 | Shift clock, asynchronous; acts on its rising edge |
| strobe | input | 1 | Latch strobe: high means transparent, low means hold |
| outEnN | input | 1 | Active-low output enable; high blanks all channels |
| serOut | output | 1 | Chain output, the shift register MSB |
| chanOn | output | CHANNELS | Channel-on vector, bit n for channel n |

## Verification
Two functions can fall in the same system cycle: a shift event, and latch transparency while the strobe is high. The bench provokes this by holding the strobe high while a whole word is shifted in. Every shift event then lands in a cycle where the latch is also copying. The outcome is judged correct only if the channels settle to the final shifted word, not to the word one shift behind. The enable and the stagger pipeline also meet when the enable toggles. That case is judged by counting the system clocks between the even and the odd channel edges.

// File: rtl/ledSinkPkg.sv
package ledSinkPkg;
  typedef struct packed {
    logic shiftEv;    // single-cycle: synchronized shift clock rose
    logic serBit;     // synchronized serial data, aligned to shiftEv
    logic latchOpen;  // synchronized strobe level
    logic blank;      // synchronized enable level, high = all off
  } ctrlStrobes_t;
endpackage

// File: rtl/ledSinkCtrl.sv
module ledSinkCtrl
  import ledSinkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftClk,
  input  logic         serIn,
  input  logic         strobe,
  input  logic         outEnN,
  output ctrlStrobes_t ctl
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync, dataSync, strobeSync, enSync;
  logic clkPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync    <= '0;
      dataSync   <= '0;
      strobeSync <= '0;
      enSync     <= '1;
      clkPrev    <= 1'b0;
    end else begin
      clkSync    <= {clkSync[TOP-1:0], shiftClk};
      dataSync   <= {dataSync[TOP-1:0], serIn};
      strobeSync <= {strobeSync[TOP-1:0], strobe};
      enSync     <= {enSync[TOP-1:0], outEnN};
      clkPrev    <= clkSync[TOP];
    end
  end

  always_comb begin
    ctl.shiftEv   = clkSync[TOP] & ~clkPrev;
    ctl.serBit    = dataSync[TOP];
    ctl.latchOpen = strobeSync[TOP];
    ctl.blank     = enSync[TOP];
  end

  // R2: a held clock level must not produce back-to-back shift events
  assert_single_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEv |=> !ctl.shiftEv);
endmodule

// File: rtl/ledSinkPath.sv
module ledSinkPath
  import ledSinkPkg::*;
#(
  parameter int CHANNELS       = 16,
  parameter int STAGGER_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        ctl,
  output logic                serOut,
  output logic [CHANNELS-1:0] chanOn
);
  function automatic logic [CHANNELS-1:0] evenBits();
    logic [CHANNELS-1:0] m;
    for (int i = 0; i < CHANNELS; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
  localparam logic [CHANNELS-1:0] EVEN_MASK = evenBits();

  logic [CHANNELS-1:0] shiftReg, latchReg, gated;
  logic [STAGGER_CYCLES:0][CHANNELS-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      latchReg <= '0;
    end else begin
      if (ctl.shiftEv) shiftReg <= {shiftReg[CHANNELS-2:0], ctl.serBit};
      if (ctl.latchOpen) latchReg <= shiftReg;
    end
  end

  assign gated  = ctl.blank ? '0 : latchReg;
  assign serOut = shiftReg[CHANNELS-1];

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else begin
      pipe[0] <= gated;
      for (int k = 1; k <= STAGGER_CYCLES; k++) pipe[k] <= pipe[k-1];
    end
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    if (i % 2 == 1) begin : g_odd
      assign chanOn[i] = pipe[STAGGER_CYCLES][i];
    end else begin : g_even
      assign chanOn[i] = pipe[0][i];
    end
  end

  // R2: a shift event moves the word up by one and inserts the serial bit
  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEv |=> shiftReg == {$past(shiftReg[CHANNELS-2:0]), $past(ctl.serBit)});
  // R4: a closed latch keeps its value
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl.latchOpen |=> latchReg == $past(latchReg));
  // R5: blanking turns the even channels off on the next edge
  assert_blank_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.blank |=> (chanOn & EVEN_MASK) == '0);
  // R7: reset leaves all channels off and the chain output low
  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (chanOn == '0) && !serOut);
endmodule

// File: rtl/ledSinkCore.sv
module ledSinkCore
  import ledSinkPkg::*;
#(
  parameter int CHANNELS       = 16,
  parameter int STAGGER_CYCLES = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic                shiftClk,
  input  logic                strobe,
  input  logic                outEnN,
  output logic                serOut,
  output logic [CHANNELS-1:0] chanOn
);
  ctrlStrobes_t ctl;

  ledSinkCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .serIn(serIn),
    .strobe(strobe), .outEnN(outEnN), .ctl(ctl)
  );

  ledSinkPath #(.CHANNELS(CHANNELS), .STAGGER_CYCLES(STAGGER_CYCLES)) u_path (
    .clk(clk), .rst(rst), .ctl(ctl), .serOut(serOut), .chanOn(chanOn)
  );
endmodule

// File: tb/ledSinkCore_bench.sv
module ledSinkCore_bench;
  localparam int N = 16;
  localparam int STG = 2;

  logic clk = 0, rst = 1, serIn = 0, shiftClk = 0, strobe = 0, outEnN = 1;
  logic serOut;
  logic [N-1:0] chanOn;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ledSinkCore #(.CHANNELS(N), .STAGGER_CYCLES(STG)) u_ledSinkCore (
    .clk(clk), .rst(rst), .serIn(serIn), .shiftClk(shiftClk),
    .strobe(strobe), .outEnN(outEnN), .serOut(serOut), .chanOn(chanOn)
  );

  // {word, enable-low level}
  localparam logic [N:0] VECS [5] = '{
    {16'hA5C3, 1'b0}, {16'h0001, 1'b0}, {16'h8000, 1'b0},
    {16'hFFFF, 1'b1}, {16'h3C69, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(logic b);
    serIn = b; waitCyc(1);
    shiftClk = 1; waitCyc(5);
    shiftClk = 0; waitCyc(5);
  endtask

  task automatic shiftWord(logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseStrobe();
    strobe = 1; waitCyc(6); strobe = 0; waitCyc(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    check("R7 reset chanOn", 32'(chanOn), 0);
    check("R7 reset serOut", 32'(serOut), 0);
    rst = 0; waitCyc(4);

    // table: shift, strobe, enable, check R1/R3/R5
    for (int v = 0; v < 5; v++) begin
      logic [N-1:0] w;
      logic oe;
      w = VECS[v][N:1]; oe = VECS[v][0];
      outEnN = oe;
      shiftWord(w);
      pulseStrobe();
      check("R1/R5 channel word", 32'(chanOn), oe ? 32'h0 : 32'(w));
      check("R3 serOut msb", 32'(serOut), 32'(w[N-1]));
    end

    // R5: enable low reveals the latch already loaded with FFFF
    outEnN = 1; shiftWord(16'hFFFF); pulseStrobe();
    check("R5 blanked", 32'(chanOn), 0);
    outEnN = 0; waitCyc(10);
    check("R5 enabled", 32'(chanOn), 32'hFFFF);

    // R6: stagger on turn-off and turn-on
    begin
      int tEven, tOdd;
      tEven = -1; tOdd = -1;
      outEnN = 1;
      for (int c = 0; c < 20; c++) begin
        waitCyc(1);
        if (tEven < 0 && !chanOn[0]) tEven = c;
        if (tOdd < 0 && !chanOn[1]) tOdd = c;
      end
      check("R6 turn-off lag", 32'(tOdd - tEven), STG);
      tEven = -1; tOdd = -1;
      outEnN = 0;
      for (int c = 0; c < 20; c++) begin
        waitCyc(1);
        if (tEven < 0 && chanOn[2]) tEven = c;
        if (tOdd < 0 && chanOn[3]) tOdd = c;
      end
      check("R6 turn-on lag", 32'(tOdd - tEven), STG);
    end

    // R4: with strobe low, a new word leaves channels unchanged
    shiftWord(16'h1234);
    waitCyc(10);
    check("R4 latch holds", 32'(chanOn), 32'hFFFF);
    // R3: one more shift exposes the bit taken 15 events earlier (1234 bit 14 = 0)
    shiftBit(1'b1);
    check("R3 chain bit", 32'(serOut), 0);
    shiftBit(1'b1);
    check("R3 chain bit 2", 32'(serOut), 32'((16'h1234 >> 13) & 1));

    // R2: a long held clock level causes only one shift
    shiftWord(16'h0000);
    serIn = 1; waitCyc(1); shiftClk = 1; waitCyc(40); shiftClk = 0; waitCyc(5);
    pulseStrobe();
    check("R2 single shift per edge", 32'(chanOn), 32'h0001);

    // R8: shifts coinciding with an open latch land on the channels
    strobe = 1;
    shiftWord(16'hC0DE);
    waitCyc(10);
    check("R8 transparent shift", 32'(chanOn), 32'hC0DE);
    strobe = 0; waitCyc(6);

    // R7: reset mid-operation
    rst = 1; waitCyc(3);
    check("R7 mid reset chanOn", 32'(chanOn), 0);
    check("R7 mid reset serOut", 32'(serOut), 0);
    rst = 0; waitCyc(4);
    pulseStrobe();
    check("R7 latch cleared", 32'(chanOn), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule